// File: doc/BRIEF.md
# Hardware Breakpoint Address Matcher

This block watches every instruction fetch and every data access issued by a processor core. It compares each one against four programmable breakpoint channels. When any enabled channel matches, the block pulses a trap line for one cycle and records the hit in a sticky per-channel status vector. Software programs a whole channel in one register write. That write carries an enable, a match type, a length code and a linear address, and the address is compared before any page translation.

A data channel covers an aligned window of one, two or four bytes. Any access that shares at least one byte with that window triggers it, and the access may be wider than the window or may straddle its edge. An execute channel matches only an instruction fetch whose address is exactly the programmed one, which is the first byte of the instruction including any prefixes. Its length code is ignored. Software clears status bits by writing a mask. A hit in the same cycle as a clear keeps its status bit.

Top module: `bkpt_unit`

## Requirements
- R1: After reset every channel is disabled, `trap` is 0 and `hit_status` is 4'b0000.
- R2: A channel whose enable bit is 0, or whose type code is the reserved value 2'b10, never matches any access.
- R3: An execute channel (type 2'b00) matches a fetch (`acc_kind` 2'b00) only when `acc_addr` equals the programmed address exactly. Its length code has no effect, so a fetch one byte above the programmed address does not match.
- R4: A fetch never triggers a data channel. A read (`acc_kind` 2'b01) or a write (2'b10) never triggers an execute channel. Access kind 2'b11 matches nothing.
- R5: A write-only channel (type 2'b01) matches writes and ignores reads.
- R6: A read-or-write channel (type 2'b11) matches both reads and writes.
- R7: The data window length code maps 2'b00 to 1 byte, 2'b01 to 2 bytes, and 2'b10 or 2'b11 to 4 bytes. The window starts at the programmed address rounded down to a multiple of its length, so the low address bits are ignored.
- R8: The access size code maps 2'b00 to 1 byte, 2'b01 to 2 bytes, and 2'b10 or 2'b11 to 4 bytes. A data access matches when any of its bytes falls inside the window, partial overlap included. Addresses do not wrap past 32'hFFFFFFFF.
- R9: `trap` is high in exactly the cycle after each valid access that matched at least one channel. Back-to-back matching accesses give back-to-back pulses.
- R10: A `hit_status` bit is set in the cycle after a matching access and then stays set. A write with `clr_we` high clears every bit set in `clr_mask`. If a new hit and a clear fall on the same bit in the same cycle, the hit wins.
- R11: A channel write takes effect for accesses in the following cycle. An access in the same cycle as the write is compared against the old settings.
- R12: Several channels can match one access, and each of them sets its own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Channel write strobe |
| cfg_chan | input | 2 | Channel selected by the write |
| cfg_en | input | 1 | Enable value to load |
| cfg_type | input | 2 | Match type: 00 execute, 01 write, 11 read-or-write, 10 reserved |
| cfg_len | input | 2 | Window length code |
| cfg_addr | input | 32 | Linear breakpoint address |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Status bits to clear |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 2 | Access size code |
| trap | output | 1 | One-cycle pulse after a matching access |
| hit_status | output | 4 | Sticky per-channel hit flags |

## Verification
Two pairs of events can share a cycle. A status clear can fall in the same cycle as a new hit on the same bit. A channel rewrite can fall in the same cycle as an access that the old settings match. The bench drives both coincidences on purpose. It expects the cleared bit to come back set because the hit wins. It expects the access to be judged by the old settings, and a repeat of that access in the next cycle to be judged by the new ones.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int BP_AW = 32;
  localparam int BP_EW = BP_AW + 1;

  typedef enum logic [1:0] {
    BP_EXEC  = 2'b00,
    BP_WRITE = 2'b01,
    BP_RSVD  = 2'b10,
    BP_RDWR  = 2'b11
  } bp_type_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic             en;
    bp_type_e         kind;
    logic [1:0]       len;
    logic [BP_AW-1:0] addr;
  } bp_chan_t;

  // byte count of a length or size code
  function automatic logic [2:0] span_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // round an address down to the window boundary
  function automatic logic [BP_AW-1:0] align_down(input logic [BP_AW-1:0] addr,
                                                  input logic [1:0] code);
    logic [BP_AW-1:0] low;
    low = BP_AW'(span_bytes(code) - 3'd1);
    return addr & ~low;
  endfunction

  // true when two byte ranges share at least one byte (no wrap)
  function automatic logic windows_touch(input logic [BP_AW-1:0] a_lo,
                                         input logic [2:0] a_n,
                                         input logic [BP_AW-1:0] b_lo,
                                         input logic [2:0] b_n);
    logic [BP_EW-1:0] a_end, b_end;
    a_end = {1'b0, a_lo} + BP_EW'(a_n) - BP_EW'(1);
    b_end = {1'b0, b_lo} + BP_EW'(b_n) - BP_EW'(1);
    return ({1'b0, a_lo} <= b_end) && ({1'b0, b_lo} <= a_end);
  endfunction

  // which access kinds a channel type responds to
  function automatic logic kind_allowed(input bp_type_e t, input acc_kind_e k);
    case (t)
      BP_EXEC:  return k == ACC_FETCH;
      BP_WRITE: return k == ACC_WRITE;
      BP_RDWR:  return (k == ACC_READ) || (k == ACC_WRITE);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bkpt_chan_regs.sv
module bkpt_chan_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_type,
  input  logic [1:0]       cfg_len,
  input  logic [BP_AW-1:0] cfg_addr,
  output bp_chan_t         chans [NUM_CH]
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    bp_chan_t cur;
    logic     sel;
    assign sel = cfg_we && (cfg_chan == CH_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur <= '0;
      end else if (sel) begin
        cur.en   <= cfg_en;
        cur.kind <= bp_type_e'(cfg_type);
        cur.len  <= cfg_len;
        cur.addr <= cfg_addr;
      end
    end

    assign chans[i] = cur;
  end

endmodule

// File: rtl/bkpt_window_cmp.sv
module bkpt_window_cmp
  import bkpt_pkg::*;
(
  input  bp_chan_t         chan,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic [BP_AW-1:0] acc_addr,
  input  logic [1:0]       acc_size,
  output logic             hit
);

  logic kind_ok;
  logic addr_ok;

  always_comb begin
    kind_ok = kind_allowed(chan.kind, acc_kind_e'(acc_kind));
    if (chan.kind == BP_EXEC) begin
      // execute windows are one byte at the exact instruction start
      addr_ok = (acc_addr == chan.addr);
    end else begin
      addr_ok = windows_touch(acc_addr, span_bytes(acc_size),
                              align_down(chan.addr, chan.len),
                              span_bytes(chan.len));
    end
    hit = acc_valid && chan.en && kind_ok && addr_ok;
  end

endmodule

// File: rtl/bkpt_status.sv
module bkpt_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic              trap,
  output logic [NUM_CH-1:0] hit_status
);

  logic [NUM_CH-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_status <= '0;
      trap       <= 1'b0;
    end else begin
      hit_status <= (hit_status & ~clr_eff) | set_vec;
      trap       <= |set_vec;
    end
  end

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_type,
  input  logic [1:0]        cfg_len,
  input  logic [BP_AW-1:0]  cfg_addr,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [BP_AW-1:0]  acc_addr,
  input  logic [1:0]        acc_size,
  output logic              trap,
  output logic [NUM_CH-1:0] hit_status
);

  bp_chan_t          chans [NUM_CH];
  logic [NUM_CH-1:0] chan_hit;
  logic [NUM_CH-1:0] chan_en;
  logic [NUM_CH-1:0] exec_mask;
  logic [NUM_CH-1:0] set_vec;

  bkpt_chan_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_chan (cfg_chan),
    .cfg_en   (cfg_en),
    .cfg_type (cfg_type),
    .cfg_len  (cfg_len),
    .cfg_addr (cfg_addr),
    .chans    (chans)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    bkpt_window_cmp u_cmp (
      .chan      (chans[i]),
      .acc_valid (acc_valid),
      .acc_kind  (acc_kind),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .hit       (chan_hit[i])
    );
    assign chan_en[i]   = chans[i].en;
    assign exec_mask[i] = (chans[i].kind == BP_EXEC);
  end

  assign set_vec = chan_hit;

  bkpt_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .trap       (trap),
    .hit_status (hit_status)
  );

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [1:0]        acc_kind,
  input logic              clr_we,
  input logic [NUM_CH-1:0] clr_mask,
  input logic              trap,
  input logic [NUM_CH-1:0] hit_status,
  input logic [NUM_CH-1:0] chan_hit,
  input logic [NUM_CH-1:0] chan_en,
  input logic [NUM_CH-1:0] exec_mask
);

  logic [NUM_CH-1:0] clr_now;
  logic [NUM_CH-1:0] keep_now;
  assign clr_now  = clr_we ? clr_mask : '0;
  assign keep_now = hit_status & ~clr_now;

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_hit & ~chan_en) == '0);

  // R4
  fetch_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'b00) |-> ((chan_hit & ~exec_mask) == '0));

  // R4
  data_not_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind != 2'b00) |-> ((chan_hit & exec_mask) == '0));

  // R9
  trap_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (|chan_hit)) |=> trap);

  // R9
  trap_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_valid && (|chan_hit))) |=> !trap);

  // R10
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit_status & $past(keep_now)) == $past(keep_now)));

  // R10
  hit_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_hit) |=> ((hit_status & $past(chan_hit)) == $past(chan_hit)));

  // R10
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_now & ~chan_hit)) |=> ((hit_status & $past(clr_now & ~chan_hit)) == '0));

endmodule

bind bkpt_unit bkpt_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_kind   (acc_kind),
  .clr_we     (clr_we),
  .clr_mask   (clr_mask),
  .trap       (trap),
  .hit_status (hit_status),
  .chan_hit   (chan_hit),
  .chan_en    (chan_en),
  .exec_mask  (exec_mask)
);

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;

  localparam int PERIOD = 10;
  localparam int WATCHDOG = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_chan = '0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_type = '0;
  logic [1:0]  cfg_len = '0;
  logic [31:0] cfg_addr = '0;
  logic        clr_we = 1'b0;
  logic [3:0]  clr_mask = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b11;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        trap;
  logic [3:0]  hit_status;

  bkpt_unit u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit          q_trap [$];
  logic [3:0]  q_stat [$];
  string       q_tag  [$];

  // bench model
  bit          m_en   [4];
  logic [1:0]  m_type [4];
  logic [1:0]  m_len  [4];
  logic [31:0] m_addr [4];
  logic [3:0]  m_stat = '0;

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit model_hit(input int ch, input logic [1:0] k,
                                   input logic [31:0] a, input logic [1:0] s);
    longint base, lb;
    if (!m_en[ch]) return 0;
    if (m_type[ch] == 2'b00) return (k == 2'b00) && (a == m_addr[ch]);
    if (m_type[ch] == 2'b10) return 0;
    if (k == 2'b00 || k == 2'b11) return 0;
    if (m_type[ch] == 2'b01 && k != 2'b10) return 0;
    lb = nbytes(m_len[ch]);
    base = longint'(m_addr[ch]) - (longint'(m_addr[ch]) % lb);
    for (int i = 0; i < nbytes(s); i++)
      for (int j = 0; j < lb; j++)
        if (longint'(a) + i == base + j) return 1;
    return 0;
  endfunction

  task automatic step(input bit cw, input logic [1:0] cch, input bit cen,
                      input logic [1:0] ct, input logic [1:0] cl, input logic [31:0] ca,
                      input bit cclr, input logic [3:0] cm,
                      input bit av, input logic [1:0] ak, input logic [31:0] aa,
                      input logic [1:0] asz, input string tag);
    logic [3:0] hits;
    @(negedge clk);
    cfg_we = cw; cfg_chan = cch; cfg_en = cen; cfg_type = ct; cfg_len = cl; cfg_addr = ca;
    clr_we = cclr; clr_mask = cm;
    acc_valid = av; acc_kind = ak; acc_addr = aa; acc_size = asz;
    hits = '0;
    for (int c = 0; c < 4; c++)
      if (av) hits[c] = model_hit(c, ak, aa, asz);
    m_stat = (m_stat & (cclr ? ~cm : 4'hF)) | hits;
    if (cw) begin
      m_en[cch] = cen; m_type[cch] = ct; m_len[cch] = cl; m_addr[cch] = ca;
    end
    q_trap.push_back(|hits);
    q_stat.push_back(m_stat);
    q_tag.push_back(tag);
  endtask

  task automatic prog(input logic [1:0] ch, input bit en, input logic [1:0] t,
                      input logic [1:0] l, input logic [31:0] a, input string tag);
    step(1, ch, en, t, l, a, 0, 4'h0, 0, 2'b11, 32'h0, 2'b00, tag);
  endtask

  task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s,
                     input string tag);
    step(0, 2'd0, 0, 2'd0, 2'd0, 32'h0, 0, 4'h0, 1, k, a, s, tag);
  endtask

  task automatic clr(input logic [3:0] m, input string tag);
    step(0, 2'd0, 0, 2'd0, 2'd0, 32'h0, 1, m, 0, 2'b11, 32'h0, 2'b00, tag);
  endtask

  // monitor: compares each cycle's outputs against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q_tag.size() > 0) begin
        bit el; logic [3:0] es; string et;
        el = q_trap.pop_front(); es = q_stat.pop_front(); et = q_tag.pop_front();
        n_cmp++;
        if (trap !== el || hit_status !== es) begin
          n_bad++;
          $display("FAIL %s: trap=%0b status=%b expected trap=%0b status=%b",
                   et, trap, hit_status, el, es);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_en[c] = 0; m_type[c] = '0; m_len[c] = '0; m_addr[c] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (trap !== 1'b0 || hit_status !== 4'b0) begin
      n_bad++;
      $display("FAIL R1 reset: trap=%0b status=%b expected trap=0 status=0000", trap, hit_status);
    end
    rst_n = 1'b1;

    acc(2'b00, 32'h0, 2'b00, "R1 no channel armed");
    acc(2'b01, 32'h0, 2'b10, "R1 no channel armed read");
    prog(2'd0, 1, 2'b00, 2'b11, 32'h0000_1000, "R3 program exec");
    acc(2'b00, 32'h0000_1000, 2'b10, "R3 fetch exact");
    acc(2'b00, 32'h0000_1001, 2'b00, "R3 length forced to one");
    acc(2'b01, 32'h0000_1000, 2'b10, "R4 read ignores exec");
    acc(2'b11, 32'h0000_1000, 2'b00, "R4 kind none");
    clr(4'b0001, "R10 clear ch0");
    prog(2'd1, 1, 2'b01, 2'b11, 32'h0000_2003, "R7 program write 4B");
    acc(2'b01, 32'h0000_2000, 2'b10, "R5 read ignored by write channel");
    acc(2'b10, 32'h0000_2001, 2'b00, "R7 aligned window write");
    acc(2'b10, 32'h0000_1FFE, 2'b10, "R8 partial overlap low");
    acc(2'b10, 32'h0000_2004, 2'b00, "R8 just above window");
    acc(2'b10, 32'h0000_1FFC, 2'b10, "R8 just below window");
    acc(2'b00, 32'h0000_2000, 2'b00, "R4 fetch ignores data channel");
    prog(2'd2, 1, 2'b11, 2'b01, 32'h0000_3000, "R6 program rw 2B");
    acc(2'b01, 32'h0000_3001, 2'b00, "R6 read hit");
    acc(2'b10, 32'h0000_2FFF, 2'b01, "R6 write straddle");
    acc(2'b01, 32'h0000_3002, 2'b00, "R7 2B window end");
    clr(4'b1111, "R10 clear all");
    // rewrite ch2 disabled in same cycle as an access the old settings match
    step(1, 2'd2, 0, 2'b11, 2'b01, 32'h0000_3000, 0, 4'h0, 1, 2'b01, 32'h0000_3000, 2'b00,
         "R11 access sees old settings");
    acc(2'b01, 32'h0000_3000, 2'b00, "R11 R2 disabled after write");
    prog(2'd3, 1, 2'b10, 2'b00, 32'h0000_4000, "R2 program reserved type");
    acc(2'b10, 32'h0000_4000, 2'b00, "R2 reserved type silent");
    // set wins over clear on the same bit
    step(0, 2'd0, 0, 2'd0, 2'd0, 32'h0, 1, 4'b1111, 1, 2'b10, 32'h0000_2000, 2'b00,
         "R10 hit beats clear");
    prog(2'd3, 1, 2'b11, 2'b00, 32'h0000_2000, "R12 program ch3 1B");
    clr(4'b1111, "R10 clear before multi");
    acc(2'b10, 32'h0000_2000, 2'b00, "R12 two channels one access");
    acc(2'b10, 32'h0000_2002, 2'b00, "R9 back-to-back pulse");
    acc(2'b01, 32'h0000_5000, 2'b00, "R9 pulse ends");
    prog(2'd0, 1, 2'b11, 2'b00, 32'hFFFF_FFFF, "R8 program top byte");
    acc(2'b01, 32'hFFFF_FFFE, 2'b10, "R8 access reaches top byte");
    acc(2'b01, 32'h0000_0000, 2'b00, "R8 no wrap to zero");
    clr(4'b0101, "R10 partial clear");

    @(negedge clk);
    cfg_we = 0; clr_we = 0; acc_valid = 0; acc_kind = 2'b11;
    repeat (3) @(posedge clk);
    #(PERIOD/2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule